// File: doc/BRIEF.md
# GPIO Interrupt Router and Aggregator

The block watches a bank of general-purpose inputs, organised as ports of pins that together form one port set. Every pin carries its own trigger code, enable bit and route selector. When the trigger condition holds on an enabled pin, that pin reports a pending interrupt. The pending bit is steered to exactly one of several interrupt output lines. Each line is meant for a different CPU, so separate CPUs can each service their own subset of the pins of a single port.

Software programs the pins through a small register interface. Writes take effect at the clock edge and reads are combinational. One status register exists per output line and shows the pending, enabled pins routed to that line. Writing a one to a bit of that register clears a latched edge. Each output line is the OR of its status register. Inputs pass through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every pin has trigger code 0, is disabled and is routed to line 0; `irq_o` is all zero and every register reads 0.
- R2: The configuration register of pin i (i = port*8 + pin-in-port) sits at address i. Its fields are bits [3:0] trigger code, bit 4 enable and bits [9:8] route. The status register of line L sits at address 16+L, and bit i of it belongs to pin i. Configuration registers read back what was written.
- R3: Code 1 latches a rising edge, code 2 a falling edge and code 3 either edge; an edge of the other kind is ignored.
- R4: Code 4 reports the pin while its synchronised input is high, and code 8 while it is low. Level status follows the input with no latching, and writing one to clear it has no effect.
- R5: A pin holding any code other than 1, 2, 3, 4 or 8 never shows status and never drives an output line.
- R6: A disabled pin shows no status on any line, and edges seen while it is disabled are not latched.
- R7: Edge status stays set until a one is written to its bit in the status register of the line the pin is routed to. Writing zero there, or writing one to that bit of another line's status register, leaves it set.
- R8: A pending pin appears only in the status register of its routed line, and pins of one port may be routed to different lines.
- R9: Output line L is high exactly when its status register has at least one bit set.
- R10: Rewriting the route of a pending pin moves its status to the new line in the cycle after the write, and the status is kept.
- R11: An input edge shows on `irq_o` after the third rising clock edge following the input change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_i | input | 16 | Asynchronous GPIO inputs, bit i is pin i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| irq_o | output | 4 | Interrupt output lines, one per CPU |

## Verification
The embedded properties check these rules on every cycle: a pending pin feeds at most one line, and a disabled pin or one with an illegal code shows no status. A latched edge survives every cycle that carries no matching clear, and an enabled both-edge pin latches any change. The exact three-edge latency, the field positions, route moves of pending pins and the way several pins merge on one line can only be shown by the bench's scenarios. The bench compares each of these against expected values it computes itself.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int PORTS = 2,
  parameter int PINS_PER_PORT = 8,
  parameter int LINES = 4,
  parameter int DW = 16,
  localparam int NPINS = PORTS * PINS_PER_PORT,
  localparam int RW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int AW = $clog2(NPINS + LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] gpio_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [LINES-1:0] irq_o
);

  logic [NPINS-1:0] s1, s2, prev;
  logic [NPINS-1:0] en, pend, hit, act, clr;
  logic [3:0]       trig  [NPINS];
  logic [RW-1:0]    route [NPINS];
  logic [NPINS-1:0] lstat [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= gpio_i;
      s2   <= s1;
      prev <= s2;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, edge_mode, lvl;
    logic [LINES-1:0] col;

    assign rise      = s2[i] & ~prev[i];
    assign fall      = ~s2[i] & prev[i];
    assign edge_mode = (trig[i] == 4'd1) || (trig[i] == 4'd2) || (trig[i] == 4'd3);
    assign lvl       = ((trig[i] == 4'd4) & s2[i]) | ((trig[i] == 4'd8) & ~s2[i]);
    assign hit[i]    = en[i] & (((trig[i] == 4'd1) & rise) | ((trig[i] == 4'd2) & fall) |
                                ((trig[i] == 4'd3) & (rise | fall)));
    assign act[i]    = en[i] & ((pend[i] & edge_mode) | lvl);
    assign clr[i]    = wr_en && (int'(addr) == NPINS + int'(route[i])) && wdata[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig[i]  <= '0;
        en[i]    <= 1'b0;
        route[i] <= '0;
        pend[i]  <= 1'b0;
      end else begin
        if (wr_en && int'(addr) == i) begin
          trig[i]  <= wdata[3:0];
          en[i]    <= wdata[4];
          route[i] <= wdata[8 +: RW];
        end
        if (hit[i])      pend[i] <= 1'b1;
        else if (clr[i]) pend[i] <= 1'b0;
      end
    end

    always_comb
      for (int l = 0; l < LINES; l++) col[l] = lstat[l][i];

    // R7
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr[i]) |=> pend[i]);
    // R3
    both_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && trig[i] == 4'd3 && s2[i] != prev[i]) |=> pend[i]);
    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> col == '0);
    // R5
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig[i] inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd8}) |-> col == '0);
    // R8
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_comb
      for (int i = 0; i < NPINS; i++) lstat[l][i] = act[i] & (route[i] == RW'(l));
    assign irq_o[l] = |lstat[l];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPINS; i++)
      if (int'(addr) == i) begin
        rdata[3:0]      = trig[i];
        rdata[4]        = en[i];
        rdata[8 +: RW]  = route[i];
      end
    for (int l = 0; l < LINES; l++)
      if (int'(addr) == NPINS + l) rdata[NPINS-1:0] = lstat[l];
  end

  // R1
  always_ff @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (irq_o == '0);

endmodule

// File: tb/tb_gpio_irq_router.sv
`timescale 1ns/1ps
module tb_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] gpio = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irq;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  gpio_irq_router dut (.clk(clk), .rst_n(rst_n), .gpio_i(gpio), .wr_en(wr_en),
                       .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq));

  // {pin[16:13], code[12:9], en[8], route[7:6], v0[5], v1[4], exp_irq[3:0]}
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {4'd0,  4'd1, 1'b1, 2'd0, 1'b0, 1'b1, 4'b0001},  // R3 rise
    {4'd3,  4'd1, 1'b1, 2'd2, 1'b1, 1'b0, 4'b0000},  // R3 fall ignored by rise code
    {4'd9,  4'd2, 1'b1, 2'd1, 1'b1, 1'b0, 4'b0010},  // R3 fall
    {4'd10, 4'd3, 1'b1, 2'd3, 1'b0, 1'b1, 4'b1000},  // R3 both, rising
    {4'd11, 4'd3, 1'b1, 2'd3, 1'b1, 1'b0, 4'b1000},  // R3 both, falling
    {4'd12, 4'd4, 1'b1, 2'd2, 1'b0, 1'b1, 4'b0100},  // R4 high level
    {4'd13, 4'd8, 1'b1, 2'd1, 1'b1, 1'b0, 4'b0010},  // R4 low level
    {4'd5,  4'd5, 1'b1, 2'd0, 1'b0, 1'b1, 4'b0000},  // R5 illegal code 5
    {4'd6,  4'hC, 1'b1, 2'd0, 1'b1, 1'b0, 4'b0000},  // R5 illegal code 12
    {4'd7,  4'd1, 1'b0, 2'd0, 1'b0, 1'b1, 4'b0000},  // R6 disabled
    {4'd15, 4'd4, 1'b1, 2'd0, 1'b1, 1'b1, 4'b0001}   // R4 held high
  };

  function automatic logic [15:0] cfg(input logic [3:0] code, input logic e, input logic [1:0] r);
    return {6'd0, r, 3'd0, e, code};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    addr = 5'(a);
    #0.5 d = rdata;
  endtask

  task automatic clear_all();
    for (int l = 0; l < 4; l++) wr(16 + l, 16'hFFFF);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] d;
    settle(2);
    chk("R1 irq in reset", {12'd0, irq}, 16'h0);
    rst_n = 1'b1;
    settle(2);
    chk("R1 irq after reset", {12'd0, irq}, 16'h0);
    rd(5, d);  chk("R1 pin 5 config default", d, 16'h0);
    rd(16, d); chk("R1 line 0 status", d, 16'h0);
    rd(19, d); chk("R1 line 3 status", d, 16'h0);

    wr(12, 16'h0314);
    rd(12, d); chk("R2 config readback", d, 16'h0314);
    wr(12, 16'h0);

    for (int k = 0; k < NV; k++) begin
      logic [16:0] v;
      int p;
      v = VEC[k];
      p = int'(v[16:13]);
      @(negedge clk); gpio[p] = v[5];
      settle(4);
      wr(p, cfg(v[12:9], v[8], v[7:6]));
      clear_all();
      @(negedge clk); gpio[p] = v[4];
      repeat (3) @(posedge clk);
      #1 chk($sformatf("R9 vector %0d irq", k), {12'd0, irq}, {12'd0, v[3:0]});
      rd(16 + int'(v[7:6]), d);
      chk($sformatf("R8 vector %0d status bit", k), {15'd0, d[p]}, {15'd0, (v[3:0] != 4'd0)});
      wr(p, 16'h0);
      clear_all();
      @(negedge clk); gpio[p] = 1'b0;
      settle(4);
    end

    // R11 latency
    wr(0, cfg(4'd1, 1'b1, 2'd0));
    @(negedge clk); gpio[0] = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R11 not after second edge", {12'd0, irq}, 16'h0);
    @(posedge clk);
    #1 chk("R11 after third edge", {12'd0, irq}, 16'h1);

    // R7 sticky and clear
    @(negedge clk); gpio[0] = 1'b0;
    settle(4);
    chk("R7 sticky after input falls", {12'd0, irq}, 16'h1);
    wr(17, 16'h0001);
    rd(16, d); chk("R7 clear on other line ignored", d, 16'h0001);
    wr(16, 16'h0000);
    rd(16, d); chk("R7 write zero ignored", d, 16'h0001);
    wr(16, 16'hFFFE);
    rd(16, d); chk("R7 other bits ignored", d, 16'h0001);
    wr(16, 16'h0001);
    rd(16, d); chk("R7 write one clears", d, 16'h0);
    chk("R9 line drops after clear", {12'd0, irq}, 16'h0);

    // R10 route move
    @(negedge clk); gpio[0] = 1'b1;
    settle(5);
    chk("R10 pending on line 0", {12'd0, irq}, 16'h1);
    wr(0, cfg(4'd1, 1'b1, 2'd3));
    chk("R10 moved to line 3", {12'd0, irq}, 16'h8);
    rd(19, d); chk("R10 line 3 status", d, 16'h0001);
    rd(16, d); chk("R10 line 0 empty", d, 16'h0);

    // R9 aggregation with a level pin on the same line
    wr(1, cfg(4'd4, 1'b1, 2'd3));
    @(negedge clk); gpio[1] = 1'b1;
    settle(4);
    rd(19, d); chk("R9 two pins on line 3", d, 16'h0003);
    wr(19, 16'h0001);
    chk("R9 line held by level pin", {12'd0, irq}, 16'h8);
    wr(19, 16'h0002);
    rd(19, d); chk("R4 level clear has no effect", d, 16'h0002);
    @(negedge clk); gpio[1] = 1'b0;
    settle(4);
    chk("R4 level follows input low", {12'd0, irq}, 16'h0);

    // R8 one port split across lines
    wr(2, cfg(4'd1, 1'b1, 2'd1));
    wr(4, cfg(4'd2, 1'b1, 2'd2));
    @(negedge clk); gpio[4] = 1'b1;
    settle(4);
    @(negedge clk); gpio[2] = 1'b1; gpio[4] = 1'b0;
    settle(4);
    chk("R8 port 0 split over lines 1 and 2", {12'd0, irq}, 16'h6);
    rd(17, d); chk("R8 line 1 holds pin 2 only", d, 16'h0004);
    rd(18, d); chk("R8 line 2 holds pin 4 only", d, 16'h0010);

    // R6 disable removes status, edges while disabled not latched
    wr(2, cfg(4'd1, 1'b0, 2'd1));
    chk("R6 disabled pin leaves line 1", {12'd0, irq}, 16'h4);
    wr(17, 16'h0004);
    @(negedge clk); gpio[2] = 1'b0;
    settle(2);
    @(negedge clk); gpio[2] = 1'b1;
    settle(5);
    wr(2, cfg(4'd1, 1'b1, 2'd1));
    rd(17, d); chk("R6 edge while disabled not latched", d, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule